// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block performs the stack-frame work of a subroutine call or return for a 32-bit core. It is started by a one-cycle request and, while it works, raises `busy`. It uses a request/acknowledge word port, one access at a time, to push or pop frame words. At the end it presents new stack pointer, frame pointer and program counter values together with a single-cycle `done` pulse.

A call request carries the address of the call instruction, a flag that selects the absolute-target form or the register-target form, the target address, and the current stack and frame pointers. Each frame built by a call has three words. The highest word is a reserved chaining slot that is never written. Below it is the return address, and at the bottom is the caller's frame pointer. After a call, the stack and frame pointers both point at that bottom word. A return request carries only the current frame pointer. It reloads the caller's frame pointer and the return address from the frame, and rebuilds the stack pointer from the frame pointer, not from the stack pointer.

Top module: `frame_seq`

## Requirements
- R1: The first memory access of a call is a write (`mem_we`=1) of the return address to address `sp_in - 8`.
- R2: The second and last memory access of a call is a write of `fp_in` to address `sp_in - 12`. Nothing is written to `sp_in - 4`.
- R3: When a call completes, `sp_out` and `fp_out` both equal `sp_in - 12`, and `pc_out` equals `call_target`.
- R4: The return address is `call_pc + 6` when `call_abs`=1 and `call_pc + 2` when `call_abs`=0.
- R5: A return first reads (`mem_we`=0) address `fp_in`. The word read becomes `fp_out`. It then reads `fp_in + 4`, and that word becomes `pc_out`.
- R6: When a return completes, `sp_out` equals `fp_in + 12`.
- R7: Only one access is outstanding at a time. While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged into the next cycle.
- R8: `busy` is high from the cycle after an accepted request through the `done` cycle. A request that arrives while `busy` is high has no effect on memory traffic or on the results.
- R9: `done` is high for exactly one cycle per operation. `sp_out`, `fp_out` and `pc_out` change only in a `done` cycle.
- R10: After reset, `busy`, `done` and `mem_req` are 0, and `sp_out`, `fp_out` and `pc_out` are 0.
- R11: If `call_req` and `ret_req` are both high in the same idle cycle, the call is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_req | input | 1 | Start a call sequence |
| call_abs | input | 1 | 1: absolute-target call form, 0: register-target form |
| call_pc | input | 32 | Address of the call instruction |
| call_target | input | 32 | Address the call jumps to |
| ret_req | input | 1 | Start a return sequence |
| sp_in | input | 32 | Current stack pointer, sampled on an accepted call |
| fp_in | input | 32 | Current frame pointer, sampled on an accepted request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes in this cycle |
| sp_out | output | 32 | Resulting stack pointer |
| fp_out | output | 32 | Resulting frame pointer |
| pc_out | output | 32 | Resulting program counter |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |

## Verification
The bench targets three things. It checks that a call followed by a return restores the caller's stack pointer, frame pointer and return address; a design that rebuilt SP from the wrong base, or that wrote the words in swapped slots, would hand back the wrong PC or SP. It varies acknowledge latency at random, so a design that advanced its address before the acknowledge would log accesses to the wrong addresses. It also issues requests while busy and both requests in one cycle; a design that accepted these would show extra memory accesses or corrupt results.

// File: rtl/frame_seq_pkg.sv
// Shared types for the call/return frame sequencer.
// Assumes nothing beyond standard SystemVerilog packages.
package frame_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_RA = 3'd1,
        ST_PUSH_FP = 3'd2,
        ST_POP_FP  = 3'd3,
        ST_POP_PC  = 3'd4,
        ST_DONE    = 3'd5
    } fs_state_t;
endpackage

// File: rtl/frame_seq_ctrl.sv
// Sequencing FSM: accepts a call or return request when idle, tracks
// memory acknowledges, and registers the resulting SP, FP and PC.
// Assumes mem_ack is only meaningful while the sequencer requests.
module frame_seq_ctrl
    import frame_seq_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ABS_RET_OFS = 6,
    parameter int REG_RET_OFS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              call_abs,
    input  logic [DATA_W-1:0] call_pc,
    input  logic [DATA_W-1:0] call_target,
    input  logic              ret_req,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] fp_in,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output fs_state_t         state,
    output logic [DATA_W-1:0] base_sp,
    output logic [DATA_W-1:0] base_fp,
    output logic [DATA_W-1:0] ret_addr,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] fp_out,
    output logic [DATA_W-1:0] pc_out,
    output logic              done,
    output logic              busy
);
    localparam int SLOT_BYTES = DATA_W / 8;
    localparam logic [DATA_W-1:0] FRAME_BYTES = DATA_W'(3 * SLOT_BYTES);
    localparam logic [DATA_W-1:0] ABS_OFS = DATA_W'(ABS_RET_OFS);
    localparam logic [DATA_W-1:0] REG_OFS = DATA_W'(REG_RET_OFS);

    logic [DATA_W-1:0] target_q;
    logic [DATA_W-1:0] popped_fp;

    // Busy covers every non-idle state, including the done cycle.
    assign busy = (state != ST_IDLE);

    // State transitions, operand capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            base_sp   <= '0;
            base_fp   <= '0;
            ret_addr  <= '0;
            target_q  <= '0;
            popped_fp <= '0;
            sp_out    <= '0;
            fp_out    <= '0;
            pc_out    <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (call_req) begin
                        base_sp  <= sp_in;
                        base_fp  <= fp_in;
                        ret_addr <= call_pc + (call_abs ? ABS_OFS : REG_OFS);
                        target_q <= call_target;
                        state    <= ST_PUSH_RA;
                    end else if (ret_req) begin
                        base_fp <= fp_in;
                        state   <= ST_POP_FP;
                    end
                end
                ST_PUSH_RA: if (mem_ack) state <= ST_PUSH_FP;
                ST_PUSH_FP: if (mem_ack) begin
                    sp_out <= base_sp - FRAME_BYTES;
                    fp_out <= base_sp - FRAME_BYTES;
                    pc_out <= target_q;
                    done   <= 1'b1;
                    state  <= ST_DONE;
                end
                ST_POP_FP: if (mem_ack) begin
                    popped_fp <= mem_rdata;
                    state     <= ST_POP_PC;
                end
                ST_POP_PC: if (mem_ack) begin
                    fp_out <= popped_fp;
                    pc_out <= mem_rdata;
                    sp_out <= base_fp + FRAME_BYTES;
                    done   <= 1'b1;
                    state  <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: completion pulse never lasts two cycles.
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: results move only in the done cycle.
    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(sp_out) && $stable(fp_out) && $stable(pc_out)));

    // R8: the sequencer only leaves idle because of a request.
    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(call_req || ret_req));

    // R3: a finished call leaves SP and FP equal.
    assert_call_eq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_FP && mem_ack) |=> (done && sp_out == fp_out));
endmodule

// File: rtl/frame_seq_addr.sv
// Memory-port driver: maps the current sequencer state to the word
// access it needs (address, direction, write data).
// Assumes the controller holds state until the access is acknowledged.
module frame_seq_addr
    import frame_seq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fs_state_t         state,
    input  logic [DATA_W-1:0] base_sp,
    input  logic [DATA_W-1:0] base_fp,
    input  logic [DATA_W-1:0] ret_addr,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int SLOT_BYTES = DATA_W / 8;
    localparam logic [DATA_W-1:0] ONE_SLOT = DATA_W'(SLOT_BYTES);
    localparam logic [DATA_W-1:0] TWO_SLOT = DATA_W'(2 * SLOT_BYTES);
    localparam logic [DATA_W-1:0] TRI_SLOT = DATA_W'(3 * SLOT_BYTES);

    // Decode the access belonging to each frame state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_PUSH_RA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base_sp - TWO_SLOT;
                mem_wdata = ret_addr;
            end
            ST_PUSH_FP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base_sp - TRI_SLOT;
                mem_wdata = base_fp;
            end
            ST_POP_FP: begin
                mem_req  = 1'b1;
                mem_addr = base_fp;
            end
            ST_POP_PC: begin
                mem_req  = 1'b1;
                mem_addr = base_fp + ONE_SLOT;
            end
            default: ;
        endcase
    end

    // R7: an unacknowledged access is held unchanged.
    assert_mem_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));
endmodule

// File: rtl/frame_seq.sv
// Call/return frame sequencer top: joins the control FSM and the
// memory-port driver. Assumes a single-outstanding word memory port.
module frame_seq #(
    parameter int DATA_W      = 32,
    parameter int ABS_RET_OFS = 6,
    parameter int REG_RET_OFS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              call_abs,
    input  logic [DATA_W-1:0] call_pc,
    input  logic [DATA_W-1:0] call_target,
    input  logic              ret_req,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] fp_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] fp_out,
    output logic [DATA_W-1:0] pc_out,
    output logic              done,
    output logic              busy
);
    frame_seq_pkg::fs_state_t state;
    logic [DATA_W-1:0] base_sp;
    logic [DATA_W-1:0] base_fp;
    logic [DATA_W-1:0] ret_addr;

    frame_seq_ctrl #(
        .DATA_W(DATA_W), .ABS_RET_OFS(ABS_RET_OFS), .REG_RET_OFS(REG_RET_OFS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .call_req(call_req), .call_abs(call_abs), .call_pc(call_pc),
        .call_target(call_target), .ret_req(ret_req),
        .sp_in(sp_in), .fp_in(fp_in),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .state(state), .base_sp(base_sp), .base_fp(base_fp),
        .ret_addr(ret_addr),
        .sp_out(sp_out), .fp_out(fp_out), .pc_out(pc_out),
        .done(done), .busy(busy)
    );

    frame_seq_addr #(.DATA_W(DATA_W)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .state(state), .base_sp(base_sp), .base_fp(base_fp),
        .ret_addr(ret_addr), .mem_ack(mem_ack),
        .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // R7: memory is only touched while a sequence is running.
    assert_req_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

// File: tb/tb_frame_seq.sv
module tb_frame_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 1'b0, call_abs = 1'b0, ret_req = 1'b0;
    logic [31:0] call_pc = '0, call_target = '0, sp_in = '0, fp_in = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [31:0] sp_out, fp_out, pc_out;
    logic        done, busy;

    int tests = 0, fails = 0;
    logic [31:0] mem [logic [31:0]];
    logic        log_we   [8];
    logic [31:0] log_addr [8];
    logic [31:0] log_data [8];
    int          log_n = 0;
    int          wait_cnt = 0;

    always #2.5 clk = ~clk;

    frame_seq dut (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_abs(call_abs),
        .call_pc(call_pc), .call_target(call_target), .ret_req(ret_req),
        .sp_in(sp_in), .fp_in(fp_in), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .sp_out(sp_out), .fp_out(fp_out), .pc_out(pc_out),
        .done(done), .busy(busy)
    );

    // Memory responder with random acknowledge latency.
    always @(negedge clk) begin
        mem_ack = 1'b0;
        if (mem_req) begin
            if (wait_cnt == 0) begin
                mem_ack = 1'b1;
                if (log_n < 8) begin
                    log_we[log_n] = mem_we;
                    log_addr[log_n] = mem_addr;
                    log_data[log_n] = mem_we ? mem_wdata : 32'h0;
                end
                log_n++;
                if (mem_we) mem[mem_addr] = mem_wdata;
                else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : ~mem_addr;
                wait_cnt = $urandom % 3;
            end else begin
                wait_cnt--;
            end
        end
    end

    function automatic logic [31:0] exp_ra(logic abs_f, logic [31:0] pc);
        return pc + (abs_f ? 32'd6 : 32'd2);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Wait for done; optionally pulse a stray request while busy.
    task automatic wait_done(bit stray);
        int n = 0;
        while (done !== 1'b1 && n < 200) begin
            @(negedge clk);
            if (stray && busy && n == 1) begin
                ret_req = 1'b1; call_req = 1'b1; sp_in = 32'hDEAD0000;
                fp_in = 32'hBEEF0000; call_target = 32'h12345678;
            end else begin
                ret_req = 1'b0; call_req = 1'b0;
            end
            n++;
        end
        ret_req = 1'b0; call_req = 1'b0;
        if (n >= 200) chk("R9 done timeout", 32'd0, 32'd1);
    endtask

    task automatic do_call(logic abs_f, logic [31:0] pc, logic [31:0] tgt,
                           logic [31:0] sp, logic [31:0] fp, bit stray);
        log_n = 0;
        @(negedge clk);
        call_req = 1'b1; call_abs = abs_f; call_pc = pc; call_target = tgt;
        sp_in = sp; fp_in = fp;
        @(negedge clk);
        call_req = 1'b0;
        chk("R8 busy after call", {31'd0, busy}, 32'd1);
        wait_done(stray);
        chk("R2 call access count", log_n, 32'd2);
        chk("R1 ra write we", {31'd0, log_we[0]}, 32'd1);
        chk("R1 ra write addr", log_addr[0], sp - 32'd8);
        chk("R4 ra value", log_data[0], exp_ra(abs_f, pc));
        chk("R2 fp write we", {31'd0, log_we[1]}, 32'd1);
        chk("R2 fp write addr", log_addr[1], sp - 32'd12);
        chk("R2 fp write data", log_data[1], fp);
        chk("R3 sp_out", sp_out, sp - 32'd12);
        chk("R3 fp_out", fp_out, sp - 32'd12);
        chk("R3 pc_out", pc_out, tgt);
    endtask

    task automatic do_ret(logic [31:0] fp, logic [31:0] exp_fp,
                          logic [31:0] exp_pc, bit stray);
        log_n = 0;
        @(negedge clk);
        ret_req = 1'b1; fp_in = fp;
        @(negedge clk);
        ret_req = 1'b0;
        chk("R8 busy after ret", {31'd0, busy}, 32'd1);
        wait_done(stray);
        chk("R5 ret access count", log_n, 32'd2);
        chk("R5 first read we", {31'd0, log_we[0]}, 32'd0);
        chk("R5 first read addr", log_addr[0], fp);
        chk("R5 second read addr", log_addr[1], fp + 32'd4);
        chk("R5 fp_out", fp_out, exp_fp);
        chk("R5 pc_out", pc_out, exp_pc);
        chk("R6 sp_out", sp_out, fp + 32'd12);
    endtask

    // Check the done pulse width and hold of results afterwards.
    task automatic check_hold();
        logic [31:0] s, f, p;
        s = sp_out; f = fp_out; p = pc_out;
        @(negedge clk);
        chk("R9 done one cycle", {31'd0, done}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R9 sp hold", sp_out, s);
        chk("R9 fp hold", fp_out, f);
        chk("R9 pc hold", pc_out, p);
        chk("R8 idle again", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy", {31'd0, busy}, 32'd0);
        chk("R10 done", {31'd0, done}, 32'd0);
        chk("R10 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R10 sp_out", sp_out, 32'd0);
        chk("R10 fp_out", fp_out, 32'd0);
        chk("R10 pc_out", pc_out, 32'd0);

        // Directed: both call forms, then matching returns.
        do_call(1'b1, 32'h0000_1000, 32'h0000_2000, 32'h0010_0000, 32'h0010_0040, 0);
        check_hold();
        do_ret(32'h000F_FFF4, 32'h0010_0040, 32'h0000_1006, 0);
        check_hold();
        do_call(1'b0, 32'h0000_3002, 32'h0000_4000, 32'h0000_000C, 32'hFFFF_FFF0, 0);
        do_ret(32'h0000_0000, 32'hFFFF_FFF0, 32'h0000_3004, 0);

        // R8: stray requests while busy have no effect.
        do_call(1'b1, 32'h0000_5000, 32'h0000_6000, 32'h0020_0000, 32'h0020_0100, 1);
        check_hold();
        do_ret(32'h001F_FFF4, 32'h0020_0100, 32'h0000_5006, 1);
        check_hold();

        // R11: simultaneous call and return, call wins.
        log_n = 0;
        @(negedge clk);
        call_req = 1'b1; ret_req = 1'b1; call_abs = 1'b0;
        call_pc = 32'h0000_7000; call_target = 32'h0000_7100;
        sp_in = 32'h0030_0000; fp_in = 32'h0030_0020;
        @(negedge clk);
        call_req = 1'b0; ret_req = 1'b0;
        wait_done(0);
        chk("R11 first access is write", {31'd0, log_we[0]}, 32'd1);
        chk("R11 pc_out is target", pc_out, 32'h0000_7100);
        chk("R11 sp_out", sp_out, 32'h002F_FFF4);

        // Random call/return pairs.
        for (int i = 0; i < 40; i++) begin
            logic [31:0] sp, fp, pc, tg;
            logic ab;
            sp = {$urandom} & 32'hFFFF_FFFC;
            fp = $urandom;
            pc = {$urandom} & 32'hFFFF_FFFE;
            tg = $urandom;
            ab = $urandom % 2;
            do_call(ab, pc, tg, sp, fp, 0);
            do_ret(sp - 32'd12, fp, exp_ra(ab, pc), 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule